// File: doc/BRIEF.md
# Masked Local-Bus Interrupt Combiner

This block gathers sixteen level-sensitive interrupt requests from local-bus devices and merges them into one interrupt line for the processor. Every clock, each request is copied into its own bit of a status register. The status is ANDed with an enable mask that software can write. The registered output line is high whenever any enabled request is active.

Software reads a source register to find out which device to service. The read returns a vector code for the lowest-numbered active, enabled request: the request index plus one, shifted left by two. The code is zero when nothing is pending. The mask can be read back and written through the same register port.

The register port is run by a small state machine with two states. BUS_IDLE means no response is due. BUS_RESP means read data is presented this cycle. The IDLE-to-RESP transition happens on any accepted request. RESP-to-RESP happens on a back-to-back request. RESP-to-IDLE happens when no request follows.

Top module: `irq_combiner`

## Requirements
- R1: After reset the enable mask is 0x0010, the status register is zero, `irq_out` is low and `rd_valid` is low.
- R2: `irq_out` is registered. One clock after the inputs change, it is high exactly when (status AND mask) is non-zero.
- R3: A write to the mask register (offset 0x2) updates the mask on that clock edge. `irq_out` reflects the new mask on the same edge.
- R4: A read of the source register (offset 0x0) returns ((n+1) << 2) in the low bits, where n is the lowest-numbered bit set in (status AND mask).
- R5: A source-register read returns zero when (status AND mask) is zero, even if masked-off requests are active.
- R6: A read of the mask register returns the current 16-bit mask.
- R7: Reads of any offset other than 0x0 and 0x2 return zero. Writes to any offset other than 0x2 leave the mask unchanged.
- R8: Read data is presented with `rd_valid` high in the cycle after the request. `rd_valid` is low in any cycle that does not follow a request.
- R9: Requests are level-sensitive. A status bit clears one clock after its input drops, with no latching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 16 | Level-sensitive device interrupt requests |
| reg_req | input | 1 | Register access request, one cycle per access |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data |
| rd_valid | output | 1 | Read data valid |
| irq_out | output | 1 | Combined interrupt to the processor |

## Verification
The bench drives several requests at once and checks that the source code names the lowest enabled index, not the highest. A reversed scan would return the wrong vector. It leaves requests active but masked off and expects a zero code with the line low; logic that ignored the mask would report a phantom interrupt. It writes the mask and checks the line on the very next cycle, which catches a design that recomputes the line from the old mask. It also writes to the source and unused offsets, which catches a loose address decode that corrupts the mask.

// File: rtl/irq_combiner_pkg.sv
package irq_combiner_pkg;

    typedef enum logic [0:0] {
        BUS_IDLE = 1'b0,
        BUS_RESP = 1'b1
    } bus_state_e;

    typedef enum logic [1:0] {
        SEL_SRC  = 2'd0,
        SEL_MASK = 2'd1,
        SEL_NONE = 2'd2
    } reg_sel_e;

endpackage

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
    parameter int NUM_IRQ = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] irq_in,
    input  logic [NUM_IRQ-1:0] mask_next,
    output logic [NUM_IRQ-1:0] status_q,
    output logic               line_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0;
            line_q   <= 1'b0;
        end else begin
            status_q <= irq_in;
            line_q   <= |(irq_in & mask_next);
        end
    end

    // R9: the status copies the request levels of the previous cycle
    p_status_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> status_q == $past(irq_in));

endmodule

// File: rtl/irq_lowest_encode.sv
module irq_lowest_encode #(
    parameter int NUM_IRQ = 16,
    parameter int DATA_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_IRQ-1:0] pending,
    output logic [DATA_W-1:0]  code
);

    always_comb begin
        code = '0;
        for (int i = NUM_IRQ - 1; i >= 0; i--) begin
            if (pending[i]) begin
                code = DATA_W'(32'(i + 1) << 2);
            end
        end
    end

    // R4: any pending source yields a non-zero code aligned to a multiple of four
    p_code_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pending != '0) |-> (code != '0 && code[1:0] == 2'b00));

    // R5: no pending source yields a zero code
    p_code_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pending == '0) |-> (code == '0));

endmodule

// File: rtl/irq_reg_port.sv
module irq_reg_port
    import irq_combiner_pkg::*;
#(
    parameter int          NUM_IRQ  = 16,
    parameter int          DATA_W   = 16,
    parameter int          ADDR_W   = 4,
    parameter logic [ADDR_W-1:0] SRC_OFS  = 4'h0,
    parameter logic [ADDR_W-1:0] MASK_OFS = 4'h2,
    parameter logic [NUM_IRQ-1:0] MASK_RST = 16'h0010
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req,
    input  logic               we,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [DATA_W-1:0]  src_code,
    output logic [NUM_IRQ-1:0] mask_q,
    output logic [NUM_IRQ-1:0] mask_next,
    output logic [DATA_W-1:0]  rdata,
    output logic               rvalid
);

    bus_state_e state_q, state_d;
    reg_sel_e   sel;
    logic [DATA_W-1:0] rdata_q, rdata_d;

    always_comb begin
        if (addr == SRC_OFS)       sel = SEL_SRC;
        else if (addr == MASK_OFS) sel = SEL_MASK;
        else                       sel = SEL_NONE;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: if (req)  state_d = BUS_RESP;
            BUS_RESP: if (!req) state_d = BUS_IDLE;
            default:            state_d = BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BUS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        mask_next = mask_q;
        if (req && we && sel == SEL_MASK) begin
            mask_next = wdata[NUM_IRQ-1:0];
        end
    end

    always_comb begin
        rdata_d = rdata_q;
        if (req && !we) begin
            unique case (sel)
                SEL_SRC:  rdata_d = src_code;
                SEL_MASK: rdata_d = DATA_W'(mask_q);
                default:  rdata_d = '0;
            endcase
        end else if (req) begin
            rdata_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q  <= MASK_RST;
            rdata_q <= '0;
        end else begin
            mask_q  <= mask_next;
            rdata_q <= rdata_d;
        end
    end

    always_comb begin
        rvalid = (state_q == BUS_RESP);
        rdata  = rvalid ? rdata_q : '0;
    end

    // R7: the mask only moves on a write to its own offset
    p_mask_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(req && we && addr == MASK_OFS) |=> $stable(mask_q));

    // R8: read data valid exactly in the cycle after a request
    p_resp_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> rvalid);
    p_resp_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> !rvalid);

    // R7: unknown offsets read zero
    p_unknown_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !we && addr != SRC_OFS && addr != MASK_OFS) |=> rdata == '0);

endmodule

// File: rtl/irq_combiner.sv
module irq_combiner
    import irq_combiner_pkg::*;
#(
    parameter int NUM_IRQ = 16,
    parameter int DATA_W  = 16,
    parameter int ADDR_W  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] irq_in,
    input  logic               reg_req,
    input  logic               reg_we,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    output logic               rd_valid,
    output logic               irq_out
);

    logic [NUM_IRQ-1:0] status_q;
    logic [NUM_IRQ-1:0] mask_q;
    logic [NUM_IRQ-1:0] mask_next;
    logic [NUM_IRQ-1:0] pending;
    logic [DATA_W-1:0]  src_code;
    logic               line_q;

    assign pending = status_q & mask_q;
    assign irq_out = line_q;

    irq_status_reg #(.NUM_IRQ(NUM_IRQ)) u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_in    (irq_in),
        .mask_next (mask_next),
        .status_q  (status_q),
        .line_q    (line_q)
    );

    irq_lowest_encode #(.NUM_IRQ(NUM_IRQ), .DATA_W(DATA_W)) u_encode (
        .clk     (clk),
        .rst_n   (rst_n),
        .pending (pending),
        .code    (src_code)
    );

    irq_reg_port #(.NUM_IRQ(NUM_IRQ), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (reg_req),
        .we        (reg_we),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .src_code  (src_code),
        .mask_q    (mask_q),
        .mask_next (mask_next),
        .rdata     (reg_rdata),
        .rvalid    (rd_valid)
    );

    // R2: the line, built from next-state values, agrees with the stored status and mask
    p_line_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out == (|(status_q & mask_q)));

endmodule

// File: tb/tb_irq_combiner.sv
module tb_irq_combiner;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] irq_in = '0;
    logic        reg_req = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        rd_valid;
    logic        irq_out;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_combiner dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .rd_valid(rd_valid), .irq_out(irq_out)
    );

    function automatic logic [15:0] exp_code(input logic [15:0] pend);
        exp_code = '0;
        for (int i = 15; i >= 0; i--) if (pend[i]) exp_code = 16'((i + 1) << 2);
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_req = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_req = 1'b0; reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [3:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_req = 1'b1; reg_we = 1'b0; reg_addr = a;
        @(negedge clk);
        reg_req = 1'b0;
        check("R8 rd_valid", 16'(rd_valid), 16'd1);
        d = reg_rdata;
    endtask

    task automatic set_irq(input logic [15:0] v);
        @(negedge clk);
        irq_in = v;
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [15:0] d;
        check("R1 irq_out", 16'(irq_out), 16'd0);
        check("R1 rd_valid", 16'(rd_valid), 16'd0);
        reg_read(4'h2, d);
        check("R1 mask", d, 16'h0010);
        reg_read(4'h0, d);
        check("R1 source", d, 16'h0000);
        @(negedge clk);
        check("R8 rd_valid idle", 16'(rd_valid), 16'd0);
    endtask

    task automatic t_each_source();
        logic [15:0] d;
        reg_write(4'h2, 16'hFFFF);
        reg_read(4'h2, d);
        check("R6 mask readback", d, 16'hFFFF);
        for (int i = 0; i < 16; i++) begin
            set_irq(16'(1) << i);
            check("R2 irq_out single", 16'(irq_out), 16'd1);
            reg_read(4'h0, d);
            check("R4 single source code", d, exp_code(16'(1) << i));
        end
    endtask

    task automatic t_priority();
        logic [15:0] d;
        logic [15:0] pats [4] = '{16'h8001, 16'hF0F0, 16'h0300, 16'h8000};
        for (int k = 0; k < 4; k++) begin
            set_irq(pats[k]);
            reg_read(4'h0, d);
            check("R4 lowest wins", d, exp_code(pats[k]));
        end
    endtask

    task automatic t_masked();
        logic [15:0] d;
        reg_write(4'h2, 16'h00F0);
        set_irq(16'h0F0F);
        check("R2 masked line low", 16'(irq_out), 16'd0);
        reg_read(4'h0, d);
        check("R5 masked source zero", d, 16'h0000);
        set_irq(16'h0F4F);
        reg_read(4'h0, d);
        check("R4 partial mask", d, 16'h001C);
    endtask

    task automatic t_mask_timing();
        @(negedge clk);
        irq_in = 16'h0100;
        reg_write(4'h2, 16'h0000);
        check("R3 mask clear line", 16'(irq_out), 16'd0);
        reg_write(4'h2, 16'h0100);
        check("R3 mask set line", 16'(irq_out), 16'd1);
    endtask

    task automatic t_unknown();
        logic [15:0] d;
        reg_write(4'h2, 16'h1234);
        reg_write(4'h0, 16'hFFFF);
        reg_write(4'h6, 16'hFFFF);
        reg_write(4'hF, 16'h0000);
        reg_read(4'h2, d);
        check("R7 mask unchanged", d, 16'h1234);
        reg_read(4'h6, d);
        check("R7 unknown read zero", d, 16'h0000);
        reg_read(4'h3, d);
        check("R7 unknown read zero b", d, 16'h0000);
    endtask

    task automatic t_level();
        logic [15:0] d;
        reg_write(4'h2, 16'hFFFF);
        set_irq(16'h0006);
        reg_read(4'h0, d);
        check("R4 level pair", d, 16'h0008);
        set_irq(16'h0004);
        reg_read(4'h0, d);
        check("R9 drop releases bit", d, 16'h000C);
        set_irq(16'h0000);
        check("R9 line drops", 16'(irq_out), 16'd0);
        reg_read(4'h0, d);
        check("R5 none pending", d, 16'h0000);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_each_source();
        t_priority();
        t_masked();
        t_mask_timing();
        t_unknown();
        t_level();
        repeat (2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule